// File: doc/BRIEF.md
# Quad-Channel DAC Calibration Register File

This block sits behind a serial shifter and turns each complete 24-bit command word into register updates for a four-channel converter. Every channel keeps a gain trim, an offset trim, a clear code and a data code. A command can target one channel or load a gain or offset value into all channels at once. Commands addressed to another device, and read commands, are dropped. The gain, offset, clear and data registers of every channel are driven out continuously for a later correction stage. The offset is also brought out as a two's-complement adjustment.

A per-channel clear-enable mask decides which channels react to the clear input. The clear input may change at any time, so it passes through a two-stage synchroniser. On each rising edge, the data register of every enabled channel takes that channel's clear code in a single cycle. Disabled channels keep their data.

Top module: `dcal_regfile`

## Requirements
- R1: After reset every gain register reads 0xFFFF, every offset register 0x8000, every clear code and data register 0x0000, the clear-enable mask 0 and err_o 0.
- R2: Command word layout: bit 23 read/write (0 = write), bits 22:21 device address, bits 20:18 register select, bits 17:16 channel, bits 15:0 value. Select 010 writes the gain register of the addressed channel only.
- R3: Select 011 writes the value into the gain register of all four channels, whatever the channel field holds.
- R4: Select 100 writes the offset register of the addressed channel, and select 101 writes the value into the offset register of all four channels.
- R5: Select 110 writes the clear-code register of the addressed channel.
- R6: Select 111 loads the clear-enable mask from value bits 3:0, where bit n enables channel n. The channel field is ignored.
- R7: Select 000 writes the data register of the addressed channel.
- R8: A command with bit 23 = 1, or with a device address that differs from dev_strap, changes no register and raises no error.
- R9: Select 001 on an accepted command changes no register, and drives err_o high for exactly the one cycle after the command is sampled.
- R10: When clr_in rises, at the third rising clock edge, every channel whose mask bit is set loads its clear code into its data register. Channels whose mask bit is clear keep their data.
- R11: The clear action happens once for each rising edge of clr_in. While clr_in stays high, data writes take effect. A clear load takes priority over a data write to the same channel in the same cycle.
- R12: offset_adj_o of each channel equals the offset code minus 32768, as a signed 16-bit value.
- R13: Every write becomes visible on the outputs at the clock edge that samples cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A complete command word is present |
| cmd_word | input | 24 | Command word |
| dev_strap | input | 2 | Device address of this block |
| clr_in | input | 1 | Asynchronous clear request, active on its rising edge |
| gain_o | output | 64 | Gain codes, channel n in bits 16n+15:16n |
| offset_o | output | 64 | Offset codes, same packing |
| offset_adj_o | output | 64 | Signed offset adjustments, same packing |
| clrcode_o | output | 64 | Clear codes, same packing |
| data_o | output | 64 | Data codes, same packing |
| clr_en_o | output | 4 | Clear-enable mask |
| err_o | output | 1 | One-cycle pulse for an undefined register select |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit codes and a 2-bit channel field. With these values every channel-field value selects a real channel, and the broadcast codes reach every register in the block. Random commands cover all eight select codes, foreign device addresses and read commands. They are mixed with directed clear sequences that check the exact load cycle, the clear-versus-write priority in one cycle, and the once-per-edge behaviour while the clear input is held high.

// File: rtl/dcal_pkg.sv
package dcal_pkg;
  localparam int DEVW = 2;
  localparam int SELW = 3;

  typedef enum logic [SELW-1:0] {
    SEL_DATA     = 3'b000,
    SEL_RSVD     = 3'b001,
    SEL_GAIN     = 3'b010,
    SEL_GAIN_ALL = 3'b011,
    SEL_OFS      = 3'b100,
    SEL_OFS_ALL  = 3'b101,
    SEL_CLR      = 3'b110,
    SEL_CTRL     = 3'b111
  } regsel_e;

  typedef struct packed {
    logic            rd;
    logic [DEVW-1:0] dev;
    regsel_e         sel;
  } cmd_hdr_t;
endpackage

// File: rtl/dcal_cmd_decode.sv
module dcal_cmd_decode
  import dcal_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4,
  parameter int CAW = 2,
  localparam int CW = 1 + DEVW + SELW + CAW + DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [CW-1:0]   cmd_word,
  input  logic [DEVW-1:0] dev_strap,
  output logic [NCH-1:0]  wr_gain,
  output logic [NCH-1:0]  wr_ofs,
  output logic [NCH-1:0]  wr_clr,
  output logic [NCH-1:0]  wr_data,
  output logic            wr_mask,
  output logic            undef,
  output logic [DW-1:0]   wdata
);
  localparam int HW = 1 + DEVW + SELW;

  cmd_hdr_t       hdr;
  logic [CAW-1:0] ch;
  logic           accept;
  logic [NCH-1:0] one;

  function automatic logic [NCH-1:0] ch_onehot(input logic [CAW-1:0] c);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (c == CAW'(i));
    return m;
  endfunction

  always_comb begin
    hdr    = cmd_hdr_t'(cmd_word[CW-1 -: HW]);
    ch     = cmd_word[DW +: CAW];
    wdata  = cmd_word[DW-1:0];
    accept = cmd_valid && !hdr.rd && (hdr.dev == dev_strap);
    one    = ch_onehot(ch);
    wr_gain = '0;
    wr_ofs  = '0;
    wr_clr  = '0;
    wr_data = '0;
    wr_mask = 1'b0;
    undef   = 1'b0;
    if (accept) begin
      case (hdr.sel)
        SEL_DATA:     wr_data = one;
        SEL_GAIN:     wr_gain = one;
        SEL_GAIN_ALL: wr_gain = '1;
        SEL_OFS:      wr_ofs  = one;
        SEL_OFS_ALL:  wr_ofs  = '1;
        SEL_CLR:      wr_clr  = one;
        SEL_CTRL:     wr_mask = 1'b1;
        default:      undef   = 1'b1;
      endcase
    end
  end

  // R8
  foreign_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_word[CW-1] || cmd_word[CW-2 -: DEVW] != dev_strap)) |->
      (!undef && !wr_mask && wr_gain == '0 && wr_ofs == '0 && wr_clr == '0 && wr_data == '0));

  // R9
  undef_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!wr_mask && wr_gain == '0 && wr_ofs == '0 && wr_clr == '0 && wr_data == '0));

  // R2
  single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_data) && $countones(wr_clr) <= 1);
endmodule

// File: rtl/dcal_clr_sync.sv
module dcal_clr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_in,
  output logic clr_rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], clr_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign clr_rise = sync_q[STAGES-1] && !last_q;

  // R11
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> !clr_rise);
endmodule

// File: rtl/dcal_chan.sv
module dcal_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_gain,
  input  logic          wr_ofs,
  input  logic          wr_clr,
  input  logic          wr_data,
  input  logic          clr_ld,
  input  logic          clr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] gain,
  output logic [DW-1:0] ofs,
  output logic [DW-1:0] ofs_adj,
  output logic [DW-1:0] clr_code,
  output logic [DW-1:0] data
);
  localparam logic [DW-1:0] GAIN_RST = '1;
  localparam logic [DW-1:0] OFS_MID  = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] ofs_to_signed(input logic [DW-1:0] code);
    return code - OFS_MID;
  endfunction

  logic clr_hit;
  assign clr_hit = clr_ld && clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain     <= GAIN_RST;
      ofs      <= OFS_MID;
      clr_code <= '0;
      data     <= '0;
    end else begin
      if (wr_gain) gain     <= wdata;
      if (wr_ofs)  ofs      <= wdata;
      if (wr_clr)  clr_code <= wdata;
      if (clr_hit)      data <= clr_code;
      else if (wr_data) data <= wdata;
    end
  end

  assign ofs_adj = ofs_to_signed(ofs);

  // R10
  clr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> data == $past(clr_code));

  // R10
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ld && !clr_en && !wr_data) |=> $stable(data));

  // R13
  gain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_gain |=> gain == $past(wdata));
endmodule

// File: rtl/dcal_regfile.sv
module dcal_regfile
  import dcal_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4,
  parameter int CAW = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW = 1 + DEVW + SELW + CAW + DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CW-1:0]     cmd_word,
  input  logic [DEVW-1:0]   dev_strap,
  input  logic              clr_in,
  output logic [NCH*DW-1:0] gain_o,
  output logic [NCH*DW-1:0] offset_o,
  output logic [NCH*DW-1:0] offset_adj_o,
  output logic [NCH*DW-1:0] clrcode_o,
  output logic [NCH*DW-1:0] data_o,
  output logic [NCH-1:0]    clr_en_o,
  output logic              err_o
);
  logic [NCH-1:0] wr_gain, wr_ofs, wr_clr, wr_data;
  logic           wr_mask, undef, clr_rise;
  logic [DW-1:0]  wdata;
  logic [NCH-1:0] mask_q;
  logic           err_q;

  dcal_cmd_decode #(.DW(DW), .NCH(NCH), .CAW(CAW)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dev_strap(dev_strap), .wr_gain(wr_gain), .wr_ofs(wr_ofs), .wr_clr(wr_clr),
    .wr_data(wr_data), .wr_mask(wr_mask), .undef(undef), .wdata(wdata)
  );

  dcal_clr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .clr_rise(clr_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata[NCH-1:0];
      err_q <= undef;
    end
  end

  assign clr_en_o = mask_q;
  assign err_o    = err_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dcal_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_gain(wr_gain[g]), .wr_ofs(wr_ofs[g]), .wr_clr(wr_clr[g]),
      .wr_data(wr_data[g]), .clr_ld(clr_rise), .clr_en(mask_q[g]),
      .wdata(wdata),
      .gain(gain_o[g*DW +: DW]), .ofs(offset_o[g*DW +: DW]),
      .ofs_adj(offset_adj_o[g*DW +: DW]), .clr_code(clrcode_o[g*DW +: DW]),
      .data(data_o[g*DW +: DW])
    );

    // R3
    bcast_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&wr_gain) |=> gain_o[g*DW +: DW] == $past(wdata));

    // R4
    bcast_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&wr_ofs) |=> offset_o[g*DW +: DW] == $past(wdata));
  end

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef |=> err_o);

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> clr_en_o == $past(wdata[NCH-1:0]));
endmodule

// File: tb/tb_dcal_regfile.sv
module tb_dcal_regfile;
  localparam int NCH = 4;
  localparam int DW  = 16;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic clr_in = 1'b0;
  logic [NCH*DW-1:0] gain_o, offset_o, offset_adj_o, clrcode_o, data_o;
  logic [NCH-1:0] clr_en_o;
  logic err_o;

  always #4 clk = ~clk;

  dcal_regfile dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dev_strap(STRAP), .clr_in(clr_in), .gain_o(gain_o), .offset_o(offset_o),
    .offset_adj_o(offset_adj_o), .clrcode_o(clrcode_o), .data_o(data_o),
    .clr_en_o(clr_en_o), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  logic [15:0] m_gain [NCH];
  logic [15:0] m_ofs  [NCH];
  logic [15:0] m_clr  [NCH];
  logic [15:0] m_data [NCH];
  logic [NCH-1:0] m_mask;
  logic m_err;

  function automatic logic [23:0] mk(input logic rd, input logic [1:0] dev,
                                     input logic [2:0] sel, input logic [1:0] ch,
                                     input logic [15:0] val);
    return {rd, dev, sel, ch, val};
  endfunction

  function automatic logic [15:0] adj_of(input logic [15:0] c);
    return {~c[15], c[14:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < NCH; i++) begin
      chk({req, " gain"},   64'(gain_o[i*DW +: DW]),       64'(m_gain[i]));
      chk({req, " offset"}, 64'(offset_o[i*DW +: DW]),     64'(m_ofs[i]));
      chk({req, " R12 adj"},64'(offset_adj_o[i*DW +: DW]), 64'(adj_of(m_ofs[i])));
      chk({req, " clear"},  64'(clrcode_o[i*DW +: DW]),    64'(m_clr[i]));
      chk({req, " data"},   64'(data_o[i*DW +: DW]),       64'(m_data[i]));
    end
    chk({req, " mask"}, 64'(clr_en_o), 64'(m_mask));
    chk({req, " err"},  64'(err_o),    64'(m_err));
  endtask

  function automatic void model(input logic [23:0] w);
    logic [1:0] ch;
    ch = w[17:16];
    m_err = 1'b0;
    if (w[23] || w[22:21] != STRAP) return;
    case (w[20:18])
      3'b000: m_data[ch] = w[15:0];
      3'b010: m_gain[ch] = w[15:0];
      3'b011: for (int i = 0; i < NCH; i++) m_gain[i] = w[15:0];
      3'b100: m_ofs[ch] = w[15:0];
      3'b101: for (int i = 0; i < NCH; i++) m_ofs[i] = w[15:0];
      3'b110: m_clr[ch] = w[15:0];
      3'b111: m_mask = w[3:0];
      default: m_err = 1'b1;
    endcase
  endfunction

  // drive at negedge, the command is sampled at the next posedge; check at the following negedge (R13)
  task automatic send(input logic [23:0] w, input string req);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    model(w);
    compare(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    m_err = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NCH; i++) begin
      m_gain[i] = 16'hFFFF; m_ofs[i] = 16'h8000; m_clr[i] = 16'h0000; m_data[i] = 16'h0000;
    end
    m_mask = '0;
    m_err  = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // directed
    send(mk(0, STRAP, 3'b010, 2'd2, 16'h1234), "R2 gain single");
    send(mk(0, STRAP, 3'b011, 2'd1, 16'h0000), "R3 gain broadcast zero");
    send(mk(0, STRAP, 3'b100, 2'd3, 16'h0000), "R4 offset single min R12");
    send(mk(0, STRAP, 3'b100, 2'd0, 16'hFFFF), "R4 offset single max R12");
    send(mk(0, STRAP, 3'b101, 2'd2, 16'h7FFF), "R4 offset broadcast");
    send(mk(0, STRAP, 3'b110, 2'd0, 16'hAAAA), "R5 clear code ch0");
    send(mk(0, STRAP, 3'b110, 2'd3, 16'h5555), "R5 clear code ch3");
    send(mk(0, STRAP, 3'b111, 2'd2, 16'hFFF9), "R6 mask");
    send(mk(0, STRAP, 3'b000, 2'd1, 16'hBEEF), "R7 data ch1");
    send(mk(0, STRAP, 3'b000, 2'd0, 16'h0F0F), "R7 data ch0");
    send(mk(1, STRAP, 3'b011, 2'd0, 16'hDEAD), "R8 read ignored");
    send(mk(0, 2'b01, 3'b011, 2'd0, 16'hDEAD), "R8 foreign device ignored");
    send(mk(0, STRAP, 3'b001, 2'd0, 16'hDEAD), "R9 undefined select");
    idle(1);
    compare("R9 err single cycle");

    // clear: mask = 1001 -> ch0 and ch3 enabled
    @(negedge clk); clr_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    compare("R10 not yet loaded");
    cmd_valid = 1'b1;
    cmd_word  = mk(0, STRAP, 3'b000, 2'd0, 16'h7777);
    @(negedge clk);
    cmd_valid = 1'b0;
    m_data[0] = m_clr[0];
    m_data[3] = m_clr[3];
    compare("R10 R11 clear load with priority");
    idle(4);
    compare("R11 held high no reload");
    send(mk(0, STRAP, 3'b000, 2'd3, 16'h1357), "R11 write while clear held");
    idle(4);
    compare("R11 still held");
    @(negedge clk); clr_in = 1'b0;
    idle(4);
    compare("R11 clear falling edge no effect");
    send(mk(0, STRAP, 3'b111, 2'd0, 16'h0000), "R6 mask all off");
    @(negedge clk); clr_in = 1'b1;
    idle(5);
    compare("R10 disabled channels keep data");
    @(negedge clk); clr_in = 1'b0;
    idle(3);

    // random
    for (int n = 0; n < 400; n++) begin
      logic rd;
      logic [1:0] dev;
      rd  = ($urandom % 10) == 0;
      dev = (($urandom % 7) == 0) ? 2'($urandom) : STRAP;
      send(mk(rd, dev, 3'($urandom), 2'($urandom), 16'($urandom)), "R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (($urandom % 40) == 0) begin
        @(negedge clk); clr_in = 1'b1;
        idle(3);
        for (int i = 0; i < NCH; i++) if (m_mask[i]) m_data[i] = m_clr[i];
        compare("R10 random clear");
        @(negedge clk); clr_in = 1'b0;
        idle(3);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule